// File: doc/BRIEF.md
# Masked Data Breakpoint Comparator

This block is a debug trigger unit. It watches data transfers on a 32-bit big-endian processor bus and raises a trigger when a transfer's operand equals a programmed breakpoint value. A mask decides which bits of that value take part in the compare.

Two 32-bit registers hold the configuration: a breakpoint value register and a mask register. A small indexed debug port writes and reads them. For each transfer, the block works out which byte lanes carry the operand from the access size and the two low address bits. Only the unmasked bits inside those lanes are compared, at the same bit positions they occupy on the bus, with no shifting. A match produces a registered trigger in the following cycle.

Both registers start uninitialized. Software must program them before any trigger can be relied on.

Top module: `dbp_trigger`

## Requirements
- R1: A write with `cfg_idx` = 0x0E loads the breakpoint value register. While `cfg_idx` = 0x0E, `cfg_rdata` shows that register.
- R2: A write with `cfg_idx` = 0x0F loads the mask register. While `cfg_idx` = 0x0F, `cfg_rdata` shows that register.
- R3: Reading any index other than 0x0E or 0x0F returns zero. A write to any other index leaves both registers unchanged.
- R4: Byte access (`bus_size` = 01) uses the address bits to pick one lane. Address 00 selects bits 31:24, 01 selects bits 23:16, 10 selects bits 15:8, and 11 selects bits 7:0.
- R5: Word access (`bus_size` = 10) uses address bit 1 to pick a half. Bit 1 = 0 selects bits 31:16 and bit 1 = 1 selects bits 15:0. Address bit 0 has no effect.
- R6: Longword access (`bus_size` = 00) compares all of bits 31:0 for every address value, including misaligned ones.
- R7: A mask bit of 1 removes that bit position from the compare. A mask bit of 0 makes that bit position take part in it.
- R8: A transfer with the reserved size code 11 never produces a trigger, even when every bit is masked.
- R9: `trig` is 0 in reset. It goes high for exactly the cycle after a valid transfer whose selected, unmasked bits all equal the breakpoint value. `trig` is never high after a cycle with `bus_valid` low.
- R10: A register write affects transfers from the next clock on. A transfer presented in the same cycle as a write is compared against the old register contents.
- R11: Bits outside the selected lanes are ignored. The breakpoint value is compared at the bus bit positions of the lanes, with no shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the trigger output |
| cfg_wr | input | 1 | Debug register write strobe |
| cfg_idx | input | 5 | Debug register index for read and write |
| cfg_wdata | input | 32 | Debug register write data |
| cfg_rdata | output | 32 | Read data for the register at `cfg_idx` |
| bus_valid | input | 1 | A data transfer is present this cycle |
| bus_size | input | 2 | Access size: 00 longword, 01 byte, 10 word, 11 reserved |
| bus_addr | input | 2 | Address bits 1:0 of the transfer |
| bus_data | input | 32 | Data on the bus |
| trig | output | 1 | One-cycle breakpoint trigger pulse |

## Verification
The hardest case to reach from the ports is a register write and a transfer landing in the same cycle. Here the transfer must be judged against the old breakpoint value, even though the new value would match. The stimulus reaches it with a directed step that drives the write strobe and a matching longword transfer together, then repeats the transfer one cycle later.

A second hard case is the reserved size code under an all-ones mask. With every bit masked, a lane-only design would match trivially, so this combination is driven on purpose.

A long random phase draws bus data close to the programmed value, so that matches and near-misses both occur. Random writes land between and during transfers, and a behavioural reference model follows every cycle.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

   // Access size encoding on the bus
   typedef enum logic [1:0] {
      SZ_LONG = 2'b00,
      SZ_BYTE = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } xfer_size_e;

   localparam int unsigned LANE_BITS = 8;

endpackage

// File: rtl/dbp_regs.sv
module dbp_regs
   import dbp_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W = 5,
   parameter logic [IDX_W-1:0] VAL_IDX = 5'h0E,
   parameter logic [IDX_W-1:0] MASK_IDX = 5'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] val_q,
   output logic [DATA_W-1:0] mask_q
);

   if (VAL_IDX == MASK_IDX) begin : g_idx_chk
      $error("dbp_regs: value and mask indices must differ");
   end

   // Configuration registers carry no reset: contents are undefined until written
   always_ff @(posedge clk) begin
      if (wr && idx == VAL_IDX) val_q <= wdata;
   end

   always_ff @(posedge clk) begin
      if (wr && idx == MASK_IDX) mask_q <= wdata;
   end

   always_comb begin
      if (idx == VAL_IDX)       rdata = val_q;
      else if (idx == MASK_IDX) rdata = mask_q;
      else                      rdata = '0;
   end

   a_r1_value_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && idx == VAL_IDX) |=> (val_q == $past(wdata)));

   a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && idx == MASK_IDX) |=> (mask_q == $past(wdata)));

   a_r3_other_idx_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (idx != VAL_IDX && idx != MASK_IDX) |-> (rdata == '0));

   a_r3_other_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && idx != VAL_IDX && idx != MASK_IDX) |=> ($stable(val_q) && $stable(mask_q)));

endmodule

// File: rtl/dbp_lane_sel.sv
module dbp_lane_sel
   import dbp_pkg::*;
#(
   parameter int unsigned LANES = 4,
   localparam int unsigned AW = $clog2(LANES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  xfer_size_e       size,
   input  logic [AW-1:0]    addr,
   output logic [LANES-1:0] lane_en
);

   if (LANES != 4) begin : g_lane_chk
      $error("dbp_lane_sel: size encoding assumes four byte lanes");
   end

   // Lane 0 is the most significant byte (big-endian)
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam logic [AW-1:0] LI = AW'(g);
      logic sel;
      always_comb begin
         case (size)
            SZ_BYTE: sel = (addr == LI);
            SZ_WORD: sel = (addr[AW-1] == LI[AW-1]);
            SZ_LONG: sel = 1'b1;
            default: sel = 1'b0;
         endcase
      end
      assign lane_en[g] = sel;
   end

   a_r4_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (size == SZ_BYTE) |-> ($countones(lane_en) == 1 && lane_en[addr]));

   a_r5_word_two_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (size == SZ_WORD) |-> ($countones(lane_en) == 2 && lane_en[{addr[AW-1], 1'b0}]));

   a_r6_long_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (size == SZ_LONG) |-> (&lane_en));

   a_r8_rsvd_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (size == SZ_RSVD) |-> (lane_en == '0));

endmodule

// File: rtl/dbp_match.sv
module dbp_match
   import dbp_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned LANES = DATA_W / LANE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic [LANES-1:0]  lane_en,
   input  logic [DATA_W-1:0] data,
   input  logic [DATA_W-1:0] val_q,
   input  logic [DATA_W-1:0] mask_q,
   output logic              trig
);

   if (DATA_W % LANE_BITS != 0) begin : g_width_chk
      $error("dbp_match: data width must be a whole number of bytes");
   end

   logic [DATA_W-1:0] care;
   logic              hit;

   for (genvar g = 0; g < LANES; g++) begin : g_care
      localparam int unsigned TOP = DATA_W - 1 - g * LANE_BITS;
      assign care[TOP -: LANE_BITS] = {LANE_BITS{lane_en[g]}} & ~mask_q[TOP -: LANE_BITS];
   end

   assign hit = valid && (|lane_en) && (((data ^ val_q) & care) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig <= 1'b0;
      else        trig <= hit;
   end

   a_r9_trig_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> $past(valid));

   a_r8_no_lane_no_trig: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_en == '0) |=> !trig);

   a_r7_unmasked_diff_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && lane_en[0] && (((data ^ val_q) & ~mask_q) >> (DATA_W - LANE_BITS)) != '0) |=> !trig);

endmodule

// File: rtl/dbp_trigger.sv
module dbp_trigger
   import dbp_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W = 5,
   parameter logic [IDX_W-1:0] VAL_IDX = 5'h0E,
   parameter logic [IDX_W-1:0] MASK_IDX = 5'h0F,
   localparam int unsigned LANES = DATA_W / LANE_BITS,
   localparam int unsigned AW = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              bus_valid,
   input  logic [1:0]        bus_size,
   input  logic [AW-1:0]     bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   output logic              trig
);

   logic [DATA_W-1:0] val_q;
   logic [DATA_W-1:0] mask_q;
   logic [LANES-1:0]  lane_en;
   xfer_size_e        size_e;

   assign size_e = xfer_size_e'(bus_size);

   dbp_regs #(
      .DATA_W(DATA_W), .IDX_W(IDX_W), .VAL_IDX(VAL_IDX), .MASK_IDX(MASK_IDX)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .idx(cfg_idx), .wdata(cfg_wdata),
      .rdata(cfg_rdata), .val_q(val_q), .mask_q(mask_q)
   );

   dbp_lane_sel #(.LANES(LANES)) u_lanes (
      .clk(clk), .rst_n(rst_n), .size(size_e), .addr(bus_addr), .lane_en(lane_en)
   );

   dbp_match #(.DATA_W(DATA_W)) u_match (
      .clk(clk), .rst_n(rst_n), .valid(bus_valid), .lane_en(lane_en),
      .data(bus_data), .val_q(val_q), .mask_q(mask_q), .trig(trig)
   );

endmodule

// File: tb/tb_dbp_trigger.sv
module tb_dbp_trigger;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [4:0]  cfg_idx = 5'h00;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        bus_valid = 1'b0;
   logic [1:0]  bus_size = 2'b00;
   logic [1:0]  bus_addr = 2'b00;
   logic [31:0] bus_data = '0;
   logic        trig;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   string cur_req = "R9";

   // Reference model state
   logic [31:0] m_val;
   logic [31:0] m_mask;
   logic        exp_trig = 1'b0;

   always #4 clk = ~clk;

   dbp_trigger dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_valid(bus_valid),
      .bus_size(bus_size), .bus_addr(bus_addr), .bus_data(bus_data), .trig(trig)
   );

   function automatic logic ref_hit(logic [1:0] sz, logic [1:0] a, logic [31:0] d,
                                    logic [31:0] v, logic [31:0] m);
      int lo;
      int hi;
      case (sz)
         2'b00: begin hi = 31; lo = 0; end
         2'b01: begin hi = 31 - 8 * int'(a); lo = hi - 7; end
         2'b10: begin hi = a[1] ? 15 : 31; lo = hi - 15; end
         default: return 1'b0;
      endcase
      for (int b = lo; b <= hi; b++)
         if (!m[b] && d[b] !== v[b]) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic [31:0] ref_read(logic [4:0] i);
      if (i == 5'h0E) return m_val;
      if (i == 5'h0F) return m_mask;
      return 32'h0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) exp_trig = 1'b0;
      else begin
         exp_trig = bus_valid ? ref_hit(bus_size, bus_addr, bus_data, m_val, m_mask) : 1'b0;
         if (cfg_wr && cfg_idx == 5'h0E) m_val = cfg_wdata;
         if (cfg_wr && cfg_idx == 5'h0F) m_mask = cfg_wdata;
      end
   end

   task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the reference model
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n && !done) begin
            check({31'b0, trig}, {31'b0, exp_trig}, cur_req);
            check(cfg_rdata, ref_read(cfg_idx), cur_req);
         end
      end
   end

   task automatic wr_reg(logic [4:0] i, logic [31:0] v);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_idx = i; cfg_wdata = v;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd_chk(logic [4:0] i, logic [31:0] exp, string tag);
      @(negedge clk);
      cfg_idx = i;
      #1 check(cfg_rdata, exp, tag);
   endtask

   task automatic xfer(logic [1:0] sz, logic [1:0] a, logic [31:0] d, logic exp, string tag);
      @(negedge clk);
      bus_valid = 1'b1; bus_size = sz; bus_addr = a; bus_data = d;
      @(negedge clk);
      bus_valid = 1'b0;
      #1 check({31'b0, trig}, {31'b0, exp}, tag);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 check({31'b0, trig}, 32'h0, "R9 reset");
      rst_n = 1'b1;

      cur_req = "R1";
      wr_reg(5'h0E, 32'h1234_5678);
      rd_chk(5'h0E, 32'h1234_5678, "R1");
      cur_req = "R2";
      wr_reg(5'h0F, 32'h0000_0000);
      rd_chk(5'h0F, 32'h0000_0000, "R2");

      cur_req = "R4";
      xfer(2'b01, 2'b00, 32'h12FF_FFFF, 1'b1, "R4 lane0");
      xfer(2'b01, 2'b01, 32'hFF34_FFFF, 1'b1, "R4 lane1");
      xfer(2'b01, 2'b10, 32'h0000_5600, 1'b1, "R4 lane2");
      xfer(2'b01, 2'b11, 32'hABCD_EF78, 1'b1, "R4 lane3");
      xfer(2'b01, 2'b00, 32'h1300_0000, 1'b0, "R4 miss");
      cur_req = "R11";
      xfer(2'b01, 2'b11, 32'h0000_0012, 1'b0, "R11 no shift");
      xfer(2'b01, 2'b01, 32'h0034_0000, 1'b1, "R11 other lanes ignored");

      cur_req = "R5";
      xfer(2'b10, 2'b00, 32'h1234_0000, 1'b1, "R5 upper");
      xfer(2'b10, 2'b01, 32'h1234_9999, 1'b1, "R5 a0 ignored");
      xfer(2'b10, 2'b10, 32'hFFFF_5678, 1'b1, "R5 lower");
      xfer(2'b10, 2'b11, 32'h0000_5678, 1'b1, "R5 lower a0");
      xfer(2'b10, 2'b10, 32'h5678_0000, 1'b0, "R5 miss");

      cur_req = "R6";
      for (int a = 0; a < 4; a++)
         xfer(2'b00, 2'(a), 32'h1234_5678, 1'b1, "R6 long hit");
      xfer(2'b00, 2'b11, 32'h1234_5679, 1'b0, "R6 long miss");

      cur_req = "R7";
      wr_reg(5'h0F, 32'h0000_00FF);
      xfer(2'b00, 2'b00, 32'h1234_56AA, 1'b1, "R7 masked byte");
      xfer(2'b00, 2'b00, 32'h0234_56AA, 1'b0, "R7 unmasked bit");

      cur_req = "R8";
      wr_reg(5'h0F, 32'hFFFF_FFFF);
      xfer(2'b11, 2'b00, 32'h1234_5678, 1'b0, "R8 reserved");
      xfer(2'b11, 2'b10, 32'hDEAD_BEEF, 1'b0, "R8 reserved");
      xfer(2'b01, 2'b10, 32'hDEAD_BEEF, 1'b1, "R7 all masked byte");

      cur_req = "R3";
      wr_reg(5'h05, 32'hDEAD_BEEF);
      rd_chk(5'h05, 32'h0, "R3 other index");
      rd_chk(5'h0E, 32'h1234_5678, "R3 value kept");
      rd_chk(5'h0F, 32'hFFFF_FFFF, "R3 mask kept");

      cur_req = "R9";
      wr_reg(5'h0F, 32'h0);
      @(negedge clk);
      bus_valid = 1'b0; bus_size = 2'b00; bus_data = 32'h1234_5678;
      @(negedge clk);
      #1 check({31'b0, trig}, 32'h0, "R9 no valid");
      xfer(2'b00, 2'b00, 32'h1234_5678, 1'b1, "R9 pulse");
      @(negedge clk);
      #1 check({31'b0, trig}, 32'h0, "R9 single cycle");

      cur_req = "R10";
      @(negedge clk);
      cfg_wr = 1'b1; cfg_idx = 5'h0E; cfg_wdata = 32'h5555_5555;
      bus_valid = 1'b1; bus_size = 2'b00; bus_data = 32'h5555_5555;
      @(negedge clk);
      cfg_wr = 1'b0;
      #1 check({31'b0, trig}, 32'h0, "R10 old value used");
      @(negedge clk);
      bus_valid = 1'b0;
      #1 check({31'b0, trig}, 32'h1, "R10 new value used");

      cur_req = "R11";
      for (int k = 0; k < 4000; k++) begin
         logic [31:0] noise;
         @(negedge clk);
         noise = $urandom & $urandom & $urandom;
         cfg_wr = ($urandom % 10) == 0;
         case ($urandom % 3)
            0: cfg_idx = 5'h0E;
            1: cfg_idx = 5'h0F;
            default: cfg_idx = 5'($urandom);
         endcase
         cfg_wdata = (cfg_idx == 5'h0F) ? ($urandom & $urandom & $urandom) : $urandom;
         bus_valid = ($urandom % 10) < 7;
         bus_size = 2'($urandom);
         bus_addr = 2'($urandom);
         bus_data = (m_val & ~noise) | ($urandom & noise);
      end
      @(negedge clk);
      cfg_wr = 1'b0; bus_valid = 1'b0;
      repeat (2) @(negedge clk);
      #2 finish_run();
   end

endmodule